// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous system bus and an external asynchronous static RAM with a 16-bit data bus made of two byte lanes, 20 address bits, a pair of chip selects of opposite polarity, an output enable, a write enable and one active-low enable per byte lane. A request carries an address, write data, a per-lane byte mask and a read/write flag. The controller plays out the matching pin sequence and counts clock cycles so that each phase lasts at least its required time. It then returns a one-cycle completion pulse, together with the read data when the request was a read.

The request side is a valid/ready stream. The controller handles one access at a time, so `req_ready` is high only while it is idle. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. The request fields are sampled only on that edge. Back-pressure is a low `req_ready`, and a master holds its request until it transfers. The response side has no back-pressure: `rsp_done` is a single-cycle pulse that the master must take when it appears. A new request may transfer in the same cycle as that pulse.

Timing is set by parameters: the clock period in picoseconds, a speed grade (0 for the 55 ns part, 1 for the 70 ns part), the address set-up time and the write recovery time. Every phase length is the ceiling of its time divided by the clock period, with a minimum of one cycle. At the default 4 ns clock and grade 0, a read holds the access for 14 cycles. A write uses 1 set-up cycle, a 12-cycle strobe (45 ns) and 1 recovery cycle.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and in every cycle in which no access is in progress, the pins are held idle: `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1, all `mem_be_n` bits 1 and `mem_dq_oe`=0. In the same cycles `req_ready`=1 and `rsp_done`=0, except for the single done cycle.
- R2: A request transfers only on an edge with `req_valid` and `req_ready` both high. `req_ready` is low from the next cycle until the done cycle. `mem_addr` shows the address sampled at transfer for the whole access, whatever `req_addr`, `req_wdata` or `req_mask` do afterwards.
- R3: A read selects the device (`mem_cs_n`=0, `mem_cs`=1) with `mem_oe_n`=0, `mem_we_n`=1 and `mem_be_n` equal to the inverted mask for exactly RD cycles. RD is ceil(read time / clock period), with a read time of 55 ns for grade 0 and 70 ns for grade 1. Mask bit 0 and `mem_be_n[0]` belong to data bits 7:0; mask bit 1 and `mem_be_n[1]` belong to bits 15:8.
- R4: Read data is taken from `mem_dq_i` on the edge that ends the access. Lanes whose mask bit is 0 return zero, whatever the bus carries on them.
- R5: A write runs three phases with the device selected and `mem_oe_n`=1. In the set-up phase, `mem_we_n`=1 and all enables are high, for AS cycles. In the strobe phase, `mem_we_n`=0, `mem_be_n` is the inverted mask and `mem_dq_o` carries the write data, for WP cycles. In the recovery phase, `mem_we_n`=1 and all enables are high, for WR cycles. WP is ceil(45 ns or 55 ns, by grade / clock period). AS and WR come from their parameters, each at least one cycle.
- R6: The mask selects the lanes written: a lower-only write, an upper-only write and a full-word write change exactly the lanes named.
- R7: A write with mask 00 never pulls any byte enable low and still completes with the same timing as any other write.
- R8: `mem_dq_oe` is high only while `mem_we_n` is low. `mem_oe_n` and `mem_we_n` are never low together.
- R9: `rsp_done` is high for exactly one cycle per access. For a read it rises in the cycle after the last access cycle, with `rsp_rdata` already valid. For a write it rises in the cycle after the last recovery cycle.
- R10: Consecutive accesses are separated by at least one idle cycle with the device deselected. A request presented during the done cycle transfers in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (20) | Word address |
| req_wdata | input | DW (16) | Write data |
| req_mask | input | DW/8 (2) | Lane select, bit 0 = low byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW (16) | Read data, unselected lanes zero |
| mem_addr | output | AW (20) | SRAM address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DW/8 (2) | Byte-lane enables, active low |
| mem_dq_o | output | DW (16) | Data driven toward the SRAM |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | DW (16) | Data returned from the SRAM |

## Verification
Writes are tried with full-word, lower-only, upper-only and empty masks against a bench memory model, so that the lanes each one actually modified show on readback. Reads are tried with full, lower and upper masks while the model puts a fixed non-zero pattern on disabled lanes, which separates proper lane zero-filling from passing the bus through. Every access is traced cycle by cycle: phase lengths, enable patterns and address hold under altered request inputs are compared with the computed counts. A read at an address that differs only in its upper bits exposes truncated address driving. Accesses are issued back to back from the done cycle to cover the transfer-during-done case.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOV
  } st_e;

  // Cycles needed to cover t_ps at clock period clk_ps, never below one.
  function automatic int unsigned ticks(input int unsigned t_ps,
                                        input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    if (c == 0) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/sram_tick_cnt.sv
module sram_tick_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_pin_reg.sv
module sram_pin_reg
  import sram_ctl_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  st_e              nxt,
  input  logic [LANES-1:0] lane_mask,
  output logic             cs_n,
  output logic             cs,
  output logic             oe_n,
  output logic             we_n,
  output logic [LANES-1:0] be_n,
  output logic             dq_oe
);
  // Pins are registered from the next state so no decode glitch reaches the RAM.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n  <= 1'b1;
      cs    <= 1'b0;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      be_n  <= '1;
      dq_oe <= 1'b0;
    end else begin
      cs_n  <= 1'b0;
      cs    <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      be_n  <= '1;
      dq_oe <= 1'b0;
      case (nxt)
        ST_RD_ACC: begin
          oe_n <= 1'b0;
          be_n <= ~lane_mask;
        end
        ST_WR_SETUP, ST_WR_RECOV: ;
        ST_WR_PULSE: begin
          we_n  <= 1'b0;
          be_n  <= ~lane_mask;
          dq_oe <= 1'b1;
        end
        default: begin
          cs_n <= 1'b1;
          cs   <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int          AW            = 20,
  parameter int          DW            = 16,
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int          SPEED_GRADE   = 0,
  parameter int unsigned ADDR_SETUP_PS = 0,
  parameter int unsigned WR_RECOV_PS   = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_mask,
  output logic            rsp_done,
  output logic [DW-1:0]   rsp_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_cs_n,
  output logic            mem_cs,
  output logic            mem_oe_n,
  output logic            mem_we_n,
  output logic [DW/8-1:0] mem_be_n,
  output logic [DW-1:0]   mem_dq_o,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_dq_i
);
  localparam int          LANES    = DW / 8;
  localparam int unsigned RD_PS    = (SPEED_GRADE != 0) ? 70000 : 55000;
  localparam int unsigned WP_PS    = (SPEED_GRADE != 0) ? 55000 : 45000;
  localparam int unsigned RD_TICKS = ticks(RD_PS, CLK_PERIOD_PS);
  localparam int unsigned WP_TICKS = ticks(WP_PS, CLK_PERIOD_PS);
  localparam int unsigned AS_TICKS = ticks(ADDR_SETUP_PS, CLK_PERIOD_PS);
  localparam int unsigned WR_TICKS = ticks(WR_RECOV_PS, CLK_PERIOD_PS);
  localparam int unsigned MAX_A    = (RD_TICKS > WP_TICKS) ? RD_TICKS : WP_TICKS;
  localparam int unsigned MAX_B    = (AS_TICKS > WR_TICKS) ? AS_TICKS : WR_TICKS;
  localparam int unsigned MAX_T    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int          CNT_W    = $clog2(MAX_T + 1);

  st_e              state_q, state_d;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] mask_q, mask_d;
  logic             done_q;
  logic             accept, phase_end, cnt_load;
  logic [CNT_W-1:0] cnt_val;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mask_d    = accept ? req_mask : mask_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (accept) state_d = req_write ? ST_WR_SETUP : ST_RD_ACC;
      ST_RD_ACC:   if (phase_end) state_d = ST_IDLE;
      ST_WR_SETUP: if (phase_end) state_d = ST_WR_PULSE;
      ST_WR_PULSE: if (phase_end) state_d = ST_WR_RECOV;
      ST_WR_RECOV: if (phase_end) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // Load the phase counter on entry to every timed phase.
  assign cnt_load = (state_d != state_q) && (state_d != ST_IDLE);
  always_comb begin
    case (state_d)
      ST_RD_ACC:   cnt_val = CNT_W'(RD_TICKS - 1);
      ST_WR_SETUP: cnt_val = CNT_W'(AS_TICKS - 1);
      ST_WR_PULSE: cnt_val = CNT_W'(WP_TICKS - 1);
      ST_WR_RECOV: cnt_val = CNT_W'(WR_TICKS - 1);
      default:     cnt_val = '0;
    endcase
  end

  sram_tick_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (phase_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      done_q <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
    end
  end

  // Per-lane capture at the end of the read access; unselected lanes read zero.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rsp_rdata[8*l +: 8] <= 8'h00;
      else if (state_q == ST_RD_ACC && phase_end)
        rsp_rdata[8*l +: 8] <= mask_q[l] ? mem_dq_i[8*l +: 8] : 8'h00;
    end
  end

  sram_pin_reg #(.LANES(LANES)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt       (state_d),
    .lane_mask (mask_d),
    .cs_n      (mem_cs_n),
    .cs        (mem_cs),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .be_n      (mem_be_n),
    .dq_oe     (mem_dq_oe)
  );

  assign mem_addr = addr_q;
  assign mem_dq_o = wdata_q;
  assign rsp_done = done_q;

  // R8
  drive_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  // R8
  oe_we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && (mem_be_n == '1)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R5
  addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_cs_n && mem_cs));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  // R10
  gap_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (mem_cs_n && !mem_cs));
endmodule

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;
  localparam int CLK_PS = 4000;
  localparam int RD     = (55000 + CLK_PS - 1) / CLK_PS;
  localparam int WP     = (45000 + CLK_PS - 1) / CLK_PS;
  localparam int AS     = 1;
  localparam int WRC    = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [19:0] mem_addr;
  logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_o, mem_dq_i;

  int checks = 0, failures = 0;
  logic [15:0] model [16];
  logic [15:0] shadow [16];

  always #2ns clk = ~clk;

  sram_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  wire sel = !mem_cs_n && mem_cs;

  // SRAM model: enabled lanes read memory, others show a fixed filler.
  always_comb begin
    for (int i = 0; i < 2; i++)
      mem_dq_i[8*i +: 8] = (sel && !mem_oe_n && !mem_be_n[i])
                           ? model[mem_addr[3:0]][8*i +: 8] : 8'h5A;
  end

  always @(posedge clk) begin
    if (sel && !mem_we_n)
      for (int i = 0; i < 2; i++)
        if (!mem_be_n[i]) model[mem_addr[3:0]][8*i +: 8] <= mem_dq_o[8*i +: 8];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_pins(input string req, input string what);
    check(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe,
          req, what, {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe}, 7'b1011110);
  endtask

  task automatic do_op(input bit wr, input logic [19:0] a, input logic [15:0] d,
                       input logic [1:0] m, input logic [15:0] exp_rd);
    int n = 0, selc = 0, oec = 0, su = 0, pu = 0, rc = 0;
    int bad_addr = 0, bad_be = 0, bad_dq = 0, bad_drive = 0, bad_rdy = 0;
    bit seen = 0, got = 0;
    int total = wr ? (AS + WP + WRC) : RD;
    check(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_mask = ~m;
    check(rsp_done == 1'b0, "R9", "done dropped after one cycle", rsp_done, 0);
    while (!got && n < 200) begin
      n++;
      if (rsp_done) begin
        got = 1;
        check(n == total + 1, "R9", "done latency", n, total + 1);
        check(req_ready == 1'b1, "R2", "ready back at done", req_ready, 1);
        idle_pins("R10", "deselected in done cycle");
        if (!wr) check(rsp_rdata == exp_rd, "R4", "read data", rsp_rdata, exp_rd);
      end else begin
        if (req_ready) bad_rdy++;
        if (mem_dq_oe && mem_we_n) bad_drive++;
        if (sel) begin
          selc++;
          if (mem_addr != a) bad_addr++;
          if (wr) begin
            if (!mem_oe_n) bad_drive++;
            if (!mem_we_n) begin
              pu++; seen = 1;
              if (mem_be_n != ~m) bad_be++;
              if (!mem_dq_oe || mem_dq_o != d) bad_dq++;
            end else begin
              if (seen) rc++; else su++;
              if (mem_be_n != 2'b11 || mem_dq_oe) bad_be++;
            end
          end else begin
            if (!mem_oe_n) oec++;
            if (mem_be_n != ~m || !mem_we_n || mem_dq_oe) bad_be++;
          end
        end
        @(negedge clk);
      end
    end
    check(got, "R9", "done seen", got, 1);
    check(bad_rdy == 0, "R2", "ready low while busy", bad_rdy, 0);
    check(bad_addr == 0, "R2", "address held from transfer", bad_addr, 0);
    check(selc == total, "R3", "selected cycles", selc, total);
    check(bad_drive == 0, "R8", "bus drive / oe during write", bad_drive, 0);
    if (wr) begin
      check(su == AS, "R5", "set-up cycles", su, AS);
      check(pu == WP, "R5", "strobe cycles", pu, WP);
      check(rc == WRC, "R5", "recovery cycles", rc, WRC);
      check(bad_be == 0, (m == 2'b00) ? "R7" : "R5", "enables/data in write", bad_be, 0);
      check(bad_dq == 0, "R5", "write data on bus", bad_dq, 0);
      for (int i = 0; i < 2; i++)
        if (m[i]) shadow[a[3:0]][8*i +: 8] = d[8*i +: 8];
      check(model[a[3:0]] == shadow[a[3:0]], "R6", "lanes written", model[a[3:0]], shadow[a[3:0]]);
    end else begin
      check(oec == RD, "R3", "output enable cycles", oec, RD);
      check(bad_be == 0, "R3", "read pin pattern", bad_be, 0);
    end
  endtask

  task automatic t_reset();
    idle_pins("R1", "pins during reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_pins("R1", "pins after reset");
    check(req_ready == 1'b1 && rsp_done == 1'b0, "R1", "ready/done after reset",
          {req_ready, rsp_done}, 2'b10);
  endtask

  task automatic t_write_word();  do_op(1, 20'h00003, 16'h1234, 2'b11, 16'h0); endtask
  task automatic t_write_lower(); do_op(1, 20'h00003, 16'hEEAB, 2'b01, 16'h0); endtask
  task automatic t_write_upper(); do_op(1, 20'h00005, 16'hCD77, 2'b10, 16'h0); endtask
  task automatic t_write_empty(); do_op(1, 20'h00003, 16'hFFFF, 2'b00, 16'h0); endtask
  task automatic t_read_word();   do_op(0, 20'h00003, 16'h0, 2'b11, 16'h12AB); endtask
  task automatic t_read_lower();  do_op(0, 20'h00003, 16'h0, 2'b01, 16'h00AB); endtask
  task automatic t_read_upper();  do_op(0, 20'h00005, 16'h0, 2'b10, 16'hCD00); endtask
  task automatic t_read_high();   do_op(0, 20'hFFFF5, 16'h0, 2'b11, 16'hCD00); endtask

  initial begin
    for (int i = 0; i < 16; i++) begin model[i] = '0; shadow[i] = '0; end
    @(negedge clk);
    t_reset();
    t_write_word();
    t_write_lower();
    t_write_upper();
    t_write_empty();
    t_read_word();
    t_read_lower();
    t_read_upper();
    t_read_high();
    @(negedge clk);
    idle_pins("R1", "pins idle after last access");
    check(rsp_done == 1'b0, "R9", "done low when idle", rsp_done, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R9 watchdog expired: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule